// File: doc/BRIEF.md
# Hidden IDE Timing Configuration Port

This block sits beside an IDE (parallel ATA) host controller and watches every host access to the command-block I/O window. In normal operation each access passes through to the attached drive. A fixed unlock sequence hidden among ordinary task-file accesses switches the window into a configuration mode. While the mode is open, byte writes at small offsets reach internal timing and control registers and never reach the drive. A closing key written to the same window returns the block to pass-through.

The block holds data/recovery timing for reads and for writes for each of two devices, one address-setup value that both devices share, and an override flag. While the flag is clear, the timing outputs carry built-in defaults chosen by a clock-speed strap input. Once software has programmed the registers, writing the apply key to the control register sets the flag. From then on the outputs carry the programmed values for whichever device the ATA device-select bit currently addresses. The bus-cycle generator that uses these outputs is a separate block.

Top module: `ide_cfg_trapdoor`

## Requirements
- R1: Configuration mode opens (cfg_open high from the cycle after the last step) only after exactly this run of consecutive accesses: a 16-bit read at offset 1, a second 16-bit read at offset 1, then a byte write of value 0x03 at offset 2. That final write is not forwarded (drv_fwd low).
- R2: While the port is locked, every access that is not the expected next step of the unlock run sends the run back to idle and is forwarded to the drive (drv_fwd high). This includes a byte read at offset 1, a third 16-bit read at offset 1, a key write without both reads before it, and a wrong value at offset 2.
- R3: While the port is open, no access is forwarded. A byte write at offset 0 loads the read timing and a byte write at offset 1 loads the write timing of the device that the miscellaneous register last selected.
- R4: A byte write of 0x83 at offset 2 while the port is open closes it. A write of 0x83 at any other offset does not close it. After closing, accesses are forwarded again and writes at offsets 0 and 1 leave all timing unchanged.
- R5: Writes to the miscellaneous register (offset 6) alternate in meaning. The first write after reset carries the device number in bit 0, the next one carries the address-setup value, and so on. The alternation is kept across lock and unlock.
- R6: The address-setup output is one shared value and is the same for both values of dev_sel.
- R7: While the port is open, a read at offset 5 returns the clock strap in bit 0 and zero in bits 15:1 with host_rd_hit high. While the port is locked, reads give host_rd_hit low and are forwarded.
- R8: A control-register write (offset 3) of 0x85 sets the override, and any other value there clears it. With the override set, t_read, t_write and t_addr show the programmed values for the device chosen by dev_sel. With it clear, they show the defaults.
- R9: After reset the port is locked and the override is clear. The defaults are read = write = 0x6B and address = 0x30 when clk_strap is 0, and read = write = 0x58 and address = 0x20 when clk_strap is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_vld | input | 1 | One-cycle strobe for a host access to the command window |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_off | input | 3 | Offset within the command window |
| host_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| host_rdata | output | 16 | Configuration read data, valid when host_rd_hit is high |
| host_rd_hit | output | 1 | The read is served by the configuration port |
| drv_fwd | output | 1 | The access is passed through to the drive |
| clk_strap | input | 1 | Clock-speed strap |
| dev_sel | input | 1 | ATA device-select bit of the current cycle |
| cfg_open | output | 1 | Configuration mode is open |
| t_read | output | 8 | Active read data/recovery timing |
| t_write | output | 8 | Active write data/recovery timing |
| t_addr | output | 8 | Active shared address-setup timing |

## Verification
The bench walks a table of access sequences that break the unlock run at each step: a byte read where a 16-bit read is expected, a third 16-bit read, a wrong key value, and a key write with only one read before it. A design that counted reads loosely, or that did not restart the run on a stray access, would open the port in one of these cases. It would then also fail to forward that access to the drive. Directed tests check three more cases. The close key at the wrong offset must leave the port open. The second address-setup write must overwrite the first for both devices, so a design that kept a separate address value per device would show 0x10 for device 0. Writes made after relocking must not change the timing, so a design that did not gate register loads on the open state would take them. A control write other than the apply key, and a reset while the port is open, must both bring back the strap defaults.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_state_t;

  localparam logic [2:0] OFF_RDT   = 3'd0;
  localparam logic [2:0] OFF_WRT   = 3'd1;
  localparam logic [2:0] OFF_PROBE = 3'd1;
  localparam logic [2:0] OFF_KEY   = 3'd2;
  localparam logic [2:0] OFF_CTL   = 3'd3;
  localparam logic [2:0] OFF_STRAP = 3'd5;
  localparam logic [2:0] OFF_MISC  = 3'd6;

  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;
  localparam logic [7:0] CTL_APPLY = 8'h85;

endpackage

// File: rtl/ide_unlock_seq.sv
module ide_unlock_seq
  import ide_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_vld,
  input  logic       acc_wr,
  input  logic       acc_wide,
  input  logic [2:0] acc_off,
  input  logic [7:0] acc_byte,
  output logic       cfg_open,
  output logic       fwd
);

  seq_state_t state_q, state_d;
  logic is_probe, is_open_key, is_close_key;

  always_comb begin
    is_probe     = acc_vld && !acc_wr && acc_wide && (acc_off == OFF_PROBE);
    is_open_key  = acc_vld && acc_wr && !acc_wide && (acc_off == OFF_KEY) &&
                   (acc_byte == KEY_OPEN);
    is_close_key = acc_vld && acc_wr && !acc_wide && (acc_off == OFF_KEY) &&
                   (acc_byte == KEY_CLOSE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: state_d = is_probe ? SEQ_ONE : SEQ_IDLE;
      SEQ_ONE:  state_d = is_probe ? SEQ_TWO : SEQ_IDLE;
      SEQ_TWO:  state_d = is_open_key ? SEQ_OPEN : SEQ_IDLE;
      SEQ_OPEN: state_d = is_close_key ? SEQ_IDLE : SEQ_OPEN;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else if (acc_vld) begin
      state_q <= state_d;
    end
  end

  always_comb begin
    cfg_open = (state_q == SEQ_OPEN);
    fwd      = acc_vld && (state_q != SEQ_OPEN) &&
               !((state_q == SEQ_TWO) && is_open_key);
  end

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(is_open_key) && ($past(state_q) == SEQ_TWO)); // R1

  AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && is_close_key) |=> !cfg_open); // R4

  AST_NO_FWD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open |-> !fwd); // R3

  AST_BROKEN_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !cfg_open && !is_open_key) |-> fwd); // R2

endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_cfg_pkg::*;
#(
  parameter int TW   = 8,
  parameter int NDEV = 2,
  localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_open,
  input  logic                   acc_vld,
  input  logic                   acc_wr,
  input  logic                   acc_wide,
  input  logic [2:0]             acc_off,
  input  logic [7:0]             acc_byte,
  output logic [NDEV-1:0][TW-1:0] rd_tim,
  output logic [NDEV-1:0][TW-1:0] wr_tim,
  output logic [TW-1:0]          addr_setup,
  output logic                   override
);

  logic            cfg_wr;
  logic            misc_wr, ctl_wr;
  logic            misc_phase_q, misc_phase_d;
  logic [DEVW-1:0] cur_dev_q, cur_dev_d;
  logic [TW-1:0]   addr_q, addr_d;
  logic            ovr_q, ovr_d;
  logic            addr_en, dev_en;

  always_comb begin
    cfg_wr   = cfg_open && acc_vld && acc_wr && !acc_wide;
    misc_wr  = cfg_wr && (acc_off == OFF_MISC);
    ctl_wr   = cfg_wr && (acc_off == OFF_CTL);
    dev_en   = misc_wr && !misc_phase_q;
    addr_en  = misc_wr && misc_phase_q;
    misc_phase_d = ~misc_phase_q;
    cur_dev_d    = acc_byte[DEVW-1:0];
    addr_d       = acc_byte[TW-1:0];
    ovr_d        = (acc_byte == CTL_APPLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_phase_q <= 1'b0;
    end else if (misc_wr) begin
      misc_phase_q <= misc_phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_dev_q <= '0;
    end else if (dev_en) begin
      cur_dev_q <= cur_dev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (ctl_wr) begin
      ovr_q <= ovr_d;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic          rd_en, wr_en;
    logic [TW-1:0] rd_q, wr_q;

    always_comb begin
      rd_en = cfg_wr && (acc_off == OFF_RDT) && (cur_dev_q == DEVW'(d));
      wr_en = cfg_wr && (acc_off == OFF_WRT) && (cur_dev_q == DEVW'(d));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
      end else if (rd_en) begin
        rd_q <= acc_byte[TW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_q <= '0;
      end else if (wr_en) begin
        wr_q <= acc_byte[TW-1:0];
      end
    end

    assign rd_tim[d] = rd_q;
    assign wr_tim[d] = wr_q;
  end

  assign addr_setup = addr_q;
  assign override   = ovr_q;

  AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(rd_tim) && $stable(wr_tim) && $stable(addr_setup))); // R4

  AST_MISC_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> (misc_phase_q != $past(misc_phase_q))); // R5

  AST_APPLY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(override) |-> ($past(ctl_wr) && ($past(acc_byte) == CTL_APPLY))); // R8

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (acc_byte != CTL_APPLY)) |=> !override); // R8

endmodule

// File: rtl/ide_timing_sel.sv
module ide_timing_sel #(
  parameter int            TW     = 8,
  parameter int            NDEV   = 2,
  parameter logic [TW-1:0] DEF_T0 = 8'h6B,
  parameter logic [TW-1:0] DEF_T1 = 8'h58,
  parameter logic [TW-1:0] DEF_A0 = 8'h30,
  parameter logic [TW-1:0] DEF_A1 = 8'h20,
  localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic                    strap,
  input  logic [DEVW-1:0]         dev_sel,
  input  logic                    override,
  input  logic [NDEV-1:0][TW-1:0] rd_tim,
  input  logic [NDEV-1:0][TW-1:0] wr_tim,
  input  logic [TW-1:0]           addr_setup,
  output logic [TW-1:0]           t_read,
  output logic [TW-1:0]           t_write,
  output logic [TW-1:0]           t_addr
);

  logic [TW-1:0] def_t, def_a;

  always_comb begin
    def_t = strap ? DEF_T1 : DEF_T0;
    def_a = strap ? DEF_A1 : DEF_A0;
    if (override) begin
      t_read  = rd_tim[dev_sel];
      t_write = wr_tim[dev_sel];
      t_addr  = addr_setup;
    end else begin
      t_read  = def_t;
      t_write = def_t;
      t_addr  = def_a;
    end
  end

endmodule

// File: rtl/ide_cfg_trapdoor.sv
module ide_cfg_trapdoor
  import ide_cfg_pkg::*;
#(
  parameter int TW   = 8,
  parameter int NDEV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_vld,
  input  logic          host_wr,
  input  logic          host_wide,
  input  logic [2:0]    host_off,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          host_rd_hit,
  output logic          drv_fwd,
  input  logic          clk_strap,
  input  logic          dev_sel,
  output logic          cfg_open,
  output logic [TW-1:0] t_read,
  output logic [TW-1:0] t_write,
  output logic [TW-1:0] t_addr
);

  localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic                    open_w;
  logic [NDEV-1:0][TW-1:0] rd_tim, wr_tim;
  logic [TW-1:0]           addr_setup;
  logic                    override;

  ide_unlock_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_vld  (host_vld),
    .acc_wr   (host_wr),
    .acc_wide (host_wide),
    .acc_off  (host_off),
    .acc_byte (host_wdata[7:0]),
    .cfg_open (open_w),
    .fwd      (drv_fwd)
  );

  ide_cfg_regs #(.TW(TW), .NDEV(NDEV)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_open   (open_w),
    .acc_vld    (host_vld),
    .acc_wr     (host_wr),
    .acc_wide   (host_wide),
    .acc_off    (host_off),
    .acc_byte   (host_wdata[7:0]),
    .rd_tim     (rd_tim),
    .wr_tim     (wr_tim),
    .addr_setup (addr_setup),
    .override   (override)
  );

  ide_timing_sel #(.TW(TW), .NDEV(NDEV)) u_sel (
    .strap      (clk_strap),
    .dev_sel    (DEVW'(dev_sel)),
    .override   (override),
    .rd_tim     (rd_tim),
    .wr_tim     (wr_tim),
    .addr_setup (addr_setup),
    .t_read     (t_read),
    .t_write    (t_write),
    .t_addr     (t_addr)
  );

  always_comb begin
    cfg_open    = open_w;
    host_rd_hit = open_w && host_vld && !host_wr;
    host_rdata  = (host_rd_hit && (host_off == OFF_STRAP)) ?
                  {15'd0, clk_strap} : 16'd0;
  end

  AST_READ_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (host_vld && !host_wr) |-> (drv_fwd != host_rd_hit)); // R7

  AST_SHARED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (override && $stable(override) && $changed(dev_sel)) |-> $stable(t_addr)); // R6

endmodule

// File: tb/ide_cfg_trapdoor_test.sv
module ide_cfg_trapdoor_test;

  logic        clk, rst_n;
  logic        host_vld, host_wr, host_wide;
  logic [2:0]  host_off;
  logic [15:0] host_wdata, host_rdata;
  logic        host_rd_hit, drv_fwd, clk_strap, dev_sel, cfg_open;
  logic [7:0]  t_read, t_write, t_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic        cap_fwd, cap_hit;
  logic [15:0] cap_rdata;

  ide_cfg_trapdoor uut (
    .clk(clk), .rst_n(rst_n), .host_vld(host_vld), .host_wr(host_wr),
    .host_wide(host_wide), .host_off(host_off), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rd_hit(host_rd_hit), .drv_fwd(drv_fwd),
    .clk_strap(clk_strap), .dev_sel(dev_sel), .cfg_open(cfg_open),
    .t_read(t_read), .t_write(t_write), .t_addr(t_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {wr, wide, off[2:0], data[7:0], exp_fwd, exp_open_after}
  localparam int NV = 21;
  localparam logic [14:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b0, 1'b1},
    {1'b1, 1'b0, 3'd2, 8'h83, 1'b0, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h04, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b0, 1'b1},
    {1'b1, 1'b0, 3'd2, 8'h83, 1'b0, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic wide, input logic [2:0] off,
                     input logic [7:0] data);
    host_vld   = 1'b1;
    host_wr    = wr;
    host_wide  = wide;
    host_off   = off;
    host_wdata = {8'h00, data};
    #1;
    cap_fwd   = drv_fwd;
    cap_hit   = host_rd_hit;
    cap_rdata = host_rdata;
    @(negedge clk);
    host_vld = 1'b0;
  endtask

  task automatic unlock();
    acc(1'b0, 1'b1, 3'd1, 8'h00);
    acc(1'b0, 1'b1, 3'd1, 8'h00);
    acc(1'b1, 1'b0, 3'd2, 8'h03);
  endtask

  task automatic put(input logic [7:0] val, input logic [2:0] off);
    unlock();
    acc(1'b1, 1'b0, off, val);
    acc(1'b1, 1'b0, 3'd2, 8'h83);
  endtask

  task automatic check_defaults(input string tag);
    #1;
    check(t_read  == (clk_strap ? 8'h58 : 8'h6B), tag, 16'(t_read),  clk_strap ? 16'h58 : 16'h6B);
    check(t_write == (clk_strap ? 8'h58 : 8'h6B), tag, 16'(t_write), clk_strap ? 16'h58 : 16'h6B);
    check(t_addr  == (clk_strap ? 8'h20 : 8'h30), tag, 16'(t_addr),  clk_strap ? 16'h20 : 16'h30);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_vld = 1'b0; host_wr = 1'b0; host_wide = 1'b0;
    host_off = 3'd0; host_wdata = 16'h0; clk_strap = 1'b0; dev_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state, both strap settings
    check(cfg_open == 1'b0, "R9 locked after reset", 16'(cfg_open), 16'h0);
    check_defaults("R9 defaults strap0");
    clk_strap = 1'b1;
    check_defaults("R9 defaults strap1");
    clk_strap = 1'b0;

    // R1 R2 table of unlock and broken-sequence patterns
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][14], VEC[i][13], VEC[i][12:10], VEC[i][9:2]);
      check(cap_fwd == VEC[i][1], $sformatf("R1 R2 forward vec %0d", i),
            16'(cap_fwd), 16'(VEC[i][1]));
      check(cfg_open == VEC[i][0], $sformatf("R1 R2 open vec %0d", i),
            16'(cfg_open), 16'(VEC[i][0]));
    end

    // R4 close key at wrong offset keeps port open
    unlock();
    acc(1'b1, 1'b0, 3'd4, 8'h83);
    check(cfg_open == 1'b1, "R4 0x83 at offset 4 keeps open", 16'(cfg_open), 16'h1);
    acc(1'b1, 1'b0, 3'd2, 8'h83);
    check(cfg_open == 1'b0, "R4 close key relocks", 16'(cfg_open), 16'h0);

    // R3 R5 program device 0 then device 1
    put(8'h00, 3'd6);
    unlock();
    acc(1'b1, 1'b0, 3'd0, 8'h31);
    check(cap_fwd == 1'b0, "R3 timing write not forwarded", 16'(cap_fwd), 16'h0);
    acc(1'b1, 1'b0, 3'd2, 8'h83);
    put(8'h32, 3'd1);
    put(8'h10, 3'd6);
    put(8'h01, 3'd6);
    put(8'h44, 3'd0);
    put(8'h45, 3'd1);
    put(8'h20, 3'd6);
    check_defaults("R8 defaults before apply");

    put(8'h85, 3'd3);
    dev_sel = 1'b0; #1;
    check(t_read  == 8'h31, "R3 R8 dev0 read",  16'(t_read),  16'h31);
    check(t_write == 8'h32, "R3 R8 dev0 write", 16'(t_write), 16'h32);
    check(t_addr  == 8'h20, "R5 R6 dev0 shared addr", 16'(t_addr), 16'h20);
    dev_sel = 1'b1; #1;
    check(t_read  == 8'h44, "R3 R5 dev1 read",  16'(t_read),  16'h44);
    check(t_write == 8'h45, "R3 R5 dev1 write", 16'(t_write), 16'h45);
    check(t_addr  == 8'h20, "R6 dev1 shared addr", 16'(t_addr), 16'h20);
    dev_sel = 1'b0;

    // R7 strap readback while open, none while locked
    clk_strap = 1'b1;
    unlock();
    acc(1'b1, 1'b0, 3'd5, 8'hFF);
    acc(1'b0, 1'b1, 3'd5, 8'h00);
    check(cap_hit == 1'b1, "R7 read hit while open", 16'(cap_hit), 16'h1);
    check(cap_rdata == 16'h0001, "R7 strap readback", cap_rdata, 16'h0001);
    acc(1'b1, 1'b0, 3'd2, 8'h83);
    acc(1'b0, 1'b1, 3'd5, 8'h00);
    check(cap_hit == 1'b0, "R7 no hit while locked", 16'(cap_hit), 16'h0);
    check(cap_fwd == 1'b1, "R7 locked read forwarded", 16'(cap_fwd), 16'h1);
    clk_strap = 1'b0;

    // R4 writes after relock do not touch timing
    acc(1'b1, 1'b0, 3'd0, 8'h77);
    check(cap_fwd == 1'b1, "R4 locked write forwarded", 16'(cap_fwd), 16'h1);
    #1;
    check(t_read == 8'h31, "R4 locked write ignored", 16'(t_read), 16'h31);

    // R8 non-apply control value clears override
    put(8'h00, 3'd3);
    check_defaults("R8 override cleared");

    // R9 reset while open with override set
    put(8'h85, 3'd3);
    unlock();
    rst_n = 1'b0;
    #1;
    check(cfg_open == 1'b0, "R9 reset relocks", 16'(cfg_open), 16'h0);
    check_defaults("R9 reset clears override");
    @(negedge clk);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule